// File: doc/BRIEF.md
# Three-Bank Interrupting GPIO Controller

A memory-mapped general-purpose I/O block serving three banks of 30 pins each. Every pin has a direction bit, an output value, a pin-enable bit that gates the output driver, and a synchronised input sample. Any pin can also flag an interrupt condition: either a selected edge or a selected level, with the polarity chosen per pin. Each condition is captured in a sticky status bit, and software acknowledges it by writing zero.

Software reaches the registers through a plain 32-bit read/write bus. Reads are combinational and writes take effect at the clock edge. The copies of a given function for the three banks sit next to each other: bank n of a function lives at that function's base offset plus 4·n. Each bank drives one interrupt line. A pin contributes to that line only while it is configured as an input, its status bit is set and its enable bit is set.

Top module: `gpio_triple_bank`

## Requirements
- R1: While reset is asserted and after it, every register reads zero except direction, which reads 0x3FFFFFFF (all pins inputs), and every irq line is low.
- R2: Function base offsets are: direction 0x00, polarity 0x20, type 0x30, interrupt enable 0x40, status 0x50, pin enable 0x60, input data 0x70, output data 0x80. A bank's copy is at base + 4·bank (bank 0..2), so each bank's registers are independent.
- R3: Direction bit 1 means input and 0 means output. pin_oe for a pin is (pin enable bit AND NOT direction bit). pin_out carries the output data register.
- R4: The input data register returns each pin through a two-flop synchroniser. A pin change made between edges is visible after the second following rising edge and not after the first.
- R5: With type bit = 1 (edge), polarity 1 sets status on a rising edge and polarity 0 on a falling edge. The status bit is visible three rising edges after the pin change, stays set after the pin returns, and the opposite edge does not set it.
- R6: With type bit = 0 (level), polarity 1 means active high and 0 means active low. Status is set on every cycle the active level is present, so a clear has no lasting effect while the level persists. Once the level has gone, a clear sticks.
- R7: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R8: If a status-setting event and a write-zero clear of that bit meet at the same clock edge, the bit ends up set.
- R9: irq[b] is high exactly when some pin of bank b has direction = 1, status = 1 and interrupt enable = 1. It follows status in the same cycle.
- R10: Read bits 31:30 are always zero, and write data in bits 31:30 is dropped.
- R11: Unmapped offsets (0x10 and bank index 3 of any function) read zero and ignore writes. The input data register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pin_in | input | 90 | Pin levels, bank b pin i at bit 30·b+i |
| pin_out | output | 90 | Output data per pin |
| pin_oe | output | 90 | Output driver enable per pin |
| irq | output | 3 | Combined interrupt line per bank |

## Verification
Register writes are due one rising edge after the bus cycle that carries them. Bus reads are due in the same cycle. A pin change reaches the input data register after two rising edges, and status and irq follow after three. The bench drives every input just after a falling edge and samples just after the falling edge that follows the edge where a result is due. For R4 it also samples one edge early to show the result is not there yet. For R8 it places the clearing write so that its commit edge is exactly the third edge after the pin change.

// File: rtl/gpio_triple_bank.sv
module gpio_triple_bank #(
  parameter int NB     = 3,
  parameter int PINS   = 30,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NB*PINS-1:0]   pin_in,
  output logic [NB*PINS-1:0]   pin_out,
  output logic [NB*PINS-1:0]   pin_oe,
  output logic [NB-1:0]        irq
);

  localparam logic [3:0] F_DIR = 4'h0, F_POL = 4'h2, F_TYP = 4'h3, F_IEN = 4'h4,
                         F_STS = 4'h5, F_PEN = 4'h6, F_DIN = 4'h7, F_DOUT = 4'h8;
  localparam int PAD = DATA_W - PINS;

  logic [3:0] func;
  logic [1:0] bidx;
  logic       bank_ok, func_ok, hit;
  logic [PINS-1:0] wval;

  assign func    = bus_addr[7:4];
  assign bidx    = bus_addr[3:2];
  assign bank_ok = (32'(bidx) < NB);
  assign func_ok = (func == F_DIR) || (func == F_POL) || (func == F_TYP) || (func == F_IEN) ||
                   (func == F_STS) || (func == F_PEN) || (func == F_DIN) || (func == F_DOUT);
  assign hit     = bank_ok && func_ok;
  assign wval    = bus_wdata[PINS-1:0];

  logic [PINS-1:0] dir_q [NB];
  logic [PINS-1:0] pol_q [NB];
  logic [PINS-1:0] typ_q [NB];
  logic [PINS-1:0] ien_q [NB];
  logic [PINS-1:0] sts_q [NB];
  logic [PINS-1:0] pen_q [NB];
  logic [PINS-1:0] dout_q[NB];
  logic [PINS-1:0] s1_q  [NB];
  logic [PINS-1:0] s2_q  [NB];
  logic [PINS-1:0] s3_q  [NB];
  logic [PINS-1:0] ev    [NB];
  logic [NB-1:0]   sts_wr;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic wsel;
    logic [PINS-1:0] rise, fall;

    assign wsel      = bus_sel && bus_wr && bank_ok && (32'(bidx) == b);
    assign sts_wr[b] = wsel && (func == F_STS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[b] <= '0;
        s2_q[b] <= '0;
        s3_q[b] <= '0;
      end else begin
        s1_q[b] <= pin_in[b*PINS +: PINS];
        s2_q[b] <= s1_q[b];
        s3_q[b] <= s2_q[b];
      end
    end

    assign rise  = s2_q[b] & ~s3_q[b];
    assign fall  = ~s2_q[b] & s3_q[b];
    assign ev[b] = (typ_q[b] & ((pol_q[b] & rise) | (~pol_q[b] & fall))) |
                   (~typ_q[b] & ((pol_q[b] & s2_q[b]) | (~pol_q[b] & ~s2_q[b])));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[b]  <= '1;
        pol_q[b]  <= '0;
        typ_q[b]  <= '0;
        ien_q[b]  <= '0;
        pen_q[b]  <= '0;
        dout_q[b] <= '0;
      end else if (wsel) begin
        case (func)
          F_DIR:  dir_q[b]  <= wval;
          F_POL:  pol_q[b]  <= wval;
          F_TYP:  typ_q[b]  <= wval;
          F_IEN:  ien_q[b]  <= wval;
          F_PEN:  pen_q[b]  <= wval;
          F_DOUT: dout_q[b] <= wval;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[b] <= '0;
      else        sts_q[b] <= (sts_wr[b] ? (sts_q[b] & wval) : sts_q[b]) | ev[b];
    end

    assign pin_out[b*PINS +: PINS] = dout_q[b];
    assign pin_oe [b*PINS +: PINS] = pen_q[b] & ~dir_q[b];
    assign irq[b] = |(dir_q[b] & sts_q[b] & ien_q[b]);

    // R5/R7: only a status write can lower a status bit
    a_r7_sticky_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_wr[b] |=> ((sts_q[b] & $past(sts_q[b])) == $past(sts_q[b])));

    // R8: every event lands, even against a clearing write
    a_r8_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q[b] & $past(ev[b])) == $past(ev[b])));

    // R9: no interrupt with all enables clear
    a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q[b] == '0) |-> !irq[b]);
  end

  logic [PINS-1:0] rd;
  always_comb begin
    rd = '0;
    if (bus_sel && hit) begin
      case (func)
        F_DIR:  rd = dir_q[bidx];
        F_POL:  rd = pol_q[bidx];
        F_TYP:  rd = typ_q[bidx];
        F_IEN:  rd = ien_q[bidx];
        F_STS:  rd = sts_q[bidx];
        F_PEN:  rd = pen_q[bidx];
        F_DIN:  rd = s2_q[bidx];
        F_DOUT: rd = dout_q[bidx];
        default: rd = '0;
      endcase
    end
  end
  assign bus_rdata = {{PAD{1'b0}}, rd};

  // R10: upper read bits are never driven
  a_r10_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PINS] == '0);

  // R11: holes in the map read zero
  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !hit) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_triple_bank.sv
module tb_gpio_triple_bank;
  localparam int NB = 3, PINS = 30;
  localparam logic [31:0] ALL = 32'h3FFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NB*PINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NB-1:0] irq;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  gpio_triple_bank dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
                        .bus_rdata, .pin_in, .pin_out, .pin_oe, .irq);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] ra(input int f, input int b);
    return 8'(f * 16 + b * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setpin(input int b, input int i, input logic v);
    pin_in[b*PINS + i] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(ra(0, b), d); chk("R1 dir reset", d, ALL);
      rd(ra(5, b), d); chk("R1 status reset", d, 0);
      rd(ra(8, b), d); chk("R1 dout reset", d, 0);
    end
    chk("R1 irq reset", 32'(irq), 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(ra(8, 0), 32'h0000_1111);
    wr(ra(8, 1), 32'h2AAA_AAAA);
    wr(ra(8, 2), 32'hFFFF_FFFF);
    rd(ra(8, 0), d); chk("R2 dout bank0", d, 32'h0000_1111);
    rd(ra(8, 1), d); chk("R2 dout bank1", d, 32'h2AAA_AAAA);
    rd(ra(8, 2), d); chk("R10 dout bank2 upper bits dropped", d, ALL);
    chk("R3 pin_out bank1", 32'(pin_out[PINS +: PINS]), 32'h2AAA_AAAA);
    wr(ra(6, 1), ALL);
    wr(ra(0, 1), 32'h3FFF_0000);
    chk("R3 pin_oe bank1", 32'(pin_oe[PINS +: PINS]), 32'h0000_FFFF);
    chk("R3 pin_oe bank0 untouched", 32'(pin_oe[0 +: PINS]), 0);
    wr(ra(0, 1), ALL);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h10, ALL);
    rd(8'h10, d); chk("R11 hole 0x10 reads zero", d, 0);
    wr(ra(0, 3), 32'h0);
    rd(ra(0, 3), d); chk("R11 bank3 reads zero", d, 0);
    rd(ra(0, 0), d); chk("R11 dir bank0 unchanged", d, ALL);
    rd(ra(0, 2), d); chk("R11 dir bank2 unchanged", d, ALL);
    wr(ra(7, 0), ALL);
    rd(ra(7, 0), d); chk("R11 input data ignores write", d, 0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    setpin(0, 12, 1);
    edges(1);
    rd(ra(7, 0), d); chk("R4 din after 1 edge", d, 0);
    edges(1);
    rd(ra(7, 0), d); chk("R4 din after 2 edges", d, 32'h1 << 12);
    setpin(0, 12, 0);
    edges(2);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    logic [31:0] m = (32'h1 << 3) | (32'h1 << 7);
    wr(ra(3, 0), m);
    wr(ra(2, 0), 32'h1 << 3);
    wr(ra(4, 0), m);
    wr(ra(5, 0), 32'h0);
    rd(ra(5, 0), d); chk("R7 status cleared", d & m, 0);
    chk("R9 irq0 low with no status", 32'(irq[0]), 0);
    setpin(0, 3, 1);
    setpin(0, 7, 1);
    edges(2);
    rd(ra(5, 0), d); chk("R5 not yet after 2 edges", d & m, 0);
    edges(1);
    rd(ra(5, 0), d); chk("R5 rise sets pin3 only", d & m, 32'h1 << 3);
    chk("R9 irq0 high", 32'(irq[0]), 1);
    chk("R9 irq1 unaffected", 32'(irq[1]), 0);
    setpin(0, 3, 0);
    setpin(0, 7, 0);
    edges(3);
    rd(ra(5, 0), d); chk("R5 sticky and fall sets pin7", d & m, m);
    wr(ra(5, 0), ALL);
    rd(ra(5, 0), d); chk("R7 write one keeps", d & m, m);
    wr(ra(5, 0), ~(32'h1 << 7));
    rd(ra(5, 0), d); chk("R7 write zero clears one bit", d & m, 32'h1 << 3);
    wr(ra(0, 0), ALL & ~(32'h1 << 3));
    chk("R9 output pin masks irq", 32'(irq[0]), 0);
    wr(ra(0, 0), ALL);
    chk("R9 input pin restores irq", 32'(irq[0]), 1);
    wr(ra(4, 0), 32'h0);
    chk("R9 enable clear masks irq", 32'(irq[0]), 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    logic [31:0] m = 32'h1 << 5;
    wr(ra(2, 1), m);
    wr(ra(5, 1), 32'h0);
    rd(ra(5, 1), d); chk("R6 level high idle", d & m, 0);
    setpin(1, 5, 1);
    edges(3);
    rd(ra(5, 1), d); chk("R6 level high sets", d & m, m);
    wr(ra(5, 1), 32'h0);
    rd(ra(5, 1), d); chk("R6 clear ineffective while level", d & m, m);
    setpin(1, 5, 0);
    edges(3);
    wr(ra(5, 1), 32'h0);
    edges(2);
    rd(ra(5, 1), d); chk("R6 clear sticks after level gone", d & m, 0);
  endtask

  task automatic t_setwins;
    logic [31:0] d;
    wr(ra(3, 2), 32'h1);
    wr(ra(2, 2), 32'h1);
    wr(ra(4, 2), 32'h1);
    wr(ra(5, 2), 32'h0);
    rd(ra(5, 2), d); chk("R8 start clear", d & 32'h1, 0);
    setpin(2, 0, 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(ra(5, 2), 32'h0);
    rd(ra(5, 2), d); chk("R8 set wins over clear", d & 32'h1, 1);
    chk("R9 irq2 high", 32'(irq[2]), 1);
    wr(ra(5, 2), 32'h0);
    rd(ra(5, 2), d); chk("R8 later clear works", d & 32'h1, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    edges(1);
    t_map;
    t_unmapped;
    t_sync;
    t_edges;
    t_level;
    t_setwins;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule